// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block lives inside an external local-bus controller and decides how long each bus access is stretched. When an access begins it takes the stored 4-bit wait setting, the interface kind (SRAM-style, burst ROM or multiplexed address/data), the direction and the beat position. From these it works out a programmed number of wait cycles and counts them down. After that it may keep stretching the access for as long as the external ready input is low, if the current mode and setting allow it.

The controller writes the wait setting through a simple write strobe. It pulses `acc_start` once per access and receives `cycle_done` when the access may finish. `wait_active` marks every stretched cycle. Below 10 the setting maps to the same number of cycles. Above that the map grows in larger steps. Multiplexed mode uses its own small map that depends on direction and beat.

Top module: `bus_wait_gen`

## Requirements
- R1: Synchronous active-high reset returns the block to idle with `wait_active` and `cycle_done` low, and sets the stored wait setting to 4'b1111, so a first SRAM-style access after reset inserts 25 waits.
- R2: In SRAM-style mode (`cfg_mode` 0, and the unused code 3), settings 0 to 9 insert exactly that many wait cycles.
- R3: In SRAM-style mode, settings 10, 11, 12, 13, 14 and 15 insert 11, 13, 15, 17, 21 and 25 wait cycles.
- R4: In burst ROM mode (`cfg_mode` 1), a first beat (`later_beat` 0) uses the SRAM-style map, and a later beat (`later_beat` 1) has no programmed waits.
- R5: In multiplexed mode (`cfg_mode` 2), a first beat takes its waits from setting bits 1:0 as read/write counts: 0 gives 1/0, 1 gives 1/1, 2 gives 2/2 and 3 gives 3/3 (`is_write` 1 means write).
- R6: In multiplexed mode, a later beat inserts one wait when setting bit 2 is 1 and none when it is 0, and setting bit 3 has no effect on any multiplexed access.
- R7: External ready is active high. It is first sampled on the edge that ends the last programmed wait, or on the start edge when there are none. Each sampled low adds one more wait cycle.
- R8: In SRAM-style and burst ROM modes with a setting of 0, ready is never sampled. `cycle_done` rises in the cycle right after the start edge, with no wait cycle.
- R9: In multiplexed mode, ready extends the access at every setting, even when the programmed wait count is zero.
- R10: The setting, mode, direction and beat are captured at access start. Writing a new setting, changing the mode, or pulsing `acc_start` again during an access does not change that access.
- R11: `cycle_done` is high for exactly one clock per access, in the cycle after the last wait. `wait_active` is high in every inserted cycle and never in the same cycle as `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wset_we | input | 1 | Write strobe for the stored wait setting |
| wset_d | input | 4 | New wait setting value |
| acc_start | input | 1 | One-cycle pulse that starts an access; ignored while busy |
| cfg_mode | input | 2 | 0 SRAM-style, 1 burst ROM, 2 multiplexed, 3 treated as SRAM-style |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| later_beat | input | 1 | 1 for second and later data beats |
| ext_ready | input | 1 | External ready (polarity set by parameter, high by default) |
| wait_active | output | 1 | High during each inserted wait cycle |
| cycle_done | output | 1 | One-clock pulse when the access completes |

## Verification
The bound checker watches some rules on every cycle. It checks that `cycle_done` is a single-cycle pulse that never overlaps a wait. It checks that `wait_active` only ever drops into a done cycle. It checks that, once programmed waits are over, a low ready holds the wait and a high ready ends it. It also checks that a zero setting outside multiplexed mode finishes at once, and that multiplexed mode honours ready with zero programmed waits. The exact cycle counts of the nonlinear map for each mode, direction and beat can only be shown by the bench's scenarios. The same goes for the reset value of the setting, and for the isolation of an access from setting writes and repeated start pulses made while it runs.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
   typedef enum logic [1:0] {
      MODE_SRAM = 2'd0,
      MODE_BROM = 2'd1,
      MODE_MUX  = 2'd2,
      MODE_RSVD = 2'd3
   } bus_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_EXT  = 2'd2,
      ST_DONE = 2'd3
   } wait_state_e;
endpackage

// File: rtl/bus_wait_decode.sv
module bus_wait_decode
   import bus_wait_pkg::*;
#(
   parameter int SET_W = 4,
   parameter int CNT_W = 5
) (
   input  logic [SET_W-1:0] setting,
   input  bus_mode_e        mode,
   input  logic             is_write,
   input  logic             later_beat,
   output logic [CNT_W-1:0] n_waits,
   output logic             rdy_ok
);
   localparam int LINEAR_TOP = 10;

   function automatic logic [CNT_W-1:0] sram_map(input logic [SET_W-1:0] s);
      logic [CNT_W-1:0] r;
      if (int'(s) < LINEAR_TOP) r = CNT_W'(s);
      else begin
         case (s[2:0])
            3'd2:    r = CNT_W'(11);
            3'd3:    r = CNT_W'(13);
            3'd4:    r = CNT_W'(15);
            3'd5:    r = CNT_W'(17);
            3'd6:    r = CNT_W'(21);
            default: r = CNT_W'(25);
         endcase
      end
      return r;
   endfunction

   always_comb begin
      n_waits = '0;
      rdy_ok  = 1'b0;
      case (mode)
         MODE_MUX: begin
            rdy_ok = 1'b1;
            if (later_beat) n_waits = CNT_W'(setting[2]);
            else begin
               case (setting[1:0])
                  2'd0:    n_waits = is_write ? CNT_W'(0) : CNT_W'(1);
                  2'd1:    n_waits = CNT_W'(1);
                  2'd2:    n_waits = CNT_W'(2);
                  default: n_waits = CNT_W'(3);
               endcase
            end
         end
         MODE_BROM: begin
            rdy_ok  = (setting != '0);
            n_waits = later_beat ? '0 : sram_map(setting);
         end
         default: begin
            rdy_ok  = (setting != '0);
            n_waits = sram_map(setting);
         end
      endcase
   end
endmodule

// File: rtl/bus_wait_count.sv
module bus_wait_count #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                   cnt_q <= '0;
      else if (load)             cnt_q <= load_val;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import bus_wait_pkg::*;
#(
   parameter int   SET_W      = 4,
   parameter int   CNT_W      = 5,
   parameter logic RDY_ACT_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wset_we,
   input  logic [SET_W-1:0] wset_d,
   input  logic             acc_start,
   input  logic [1:0]       cfg_mode,
   input  logic             is_write,
   input  logic             later_beat,
   input  logic             ext_ready,
   output logic             wait_active,
   output logic             cycle_done
);
   localparam int               MAX_WAIT  = 25;
   localparam logic [SET_W-1:0] SET_RESET = '1;

   generate
      if (SET_W != 4) begin : g_bad_set
         $error("bus_wait_gen: SET_W must be 4");
      end
      if ((1 << CNT_W) <= MAX_WAIT) begin : g_bad_cnt
         $error("bus_wait_gen: CNT_W too narrow for the largest wait");
      end
   endgenerate

   logic rdy_eff;
   generate
      if (RDY_ACT_HI) begin : g_rdy_hi
         assign rdy_eff = ext_ready;
      end else begin : g_rdy_lo
         assign rdy_eff = ~ext_ready;
      end
   endgenerate

   logic [SET_W-1:0] wset_q;
   always_ff @(posedge clk) begin
      if (rst)          wset_q <= SET_RESET;
      else if (wset_we) wset_q <= wset_d;
   end

   logic [CNT_W-1:0] n_waits;
   logic             rdy_ok;

   bus_wait_decode #(.SET_W(SET_W), .CNT_W(CNT_W)) u_decode (
      .setting    (wset_q),
      .mode       (bus_mode_e'(cfg_mode)),
      .is_write   (is_write),
      .later_beat (later_beat),
      .n_waits    (n_waits),
      .rdy_ok     (rdy_ok)
   );

   wait_state_e state_q, state_d;
   logic        rdy_ok_q;
   logic        accept;
   logic        cnt_zero;

   assign accept = (state_q == ST_IDLE) && acc_start;

   bus_wait_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .load_val ((n_waits == '0) ? n_waits : n_waits - 1'b1),
      .dec      (state_q == ST_WAIT),
      .zero     (cnt_zero)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (acc_start) begin
               if (n_waits != '0)          state_d = ST_WAIT;
               else if (rdy_ok && !rdy_eff) state_d = ST_EXT;
               else                         state_d = ST_DONE;
            end
         end
         ST_WAIT: begin
            if (cnt_zero) state_d = (rdy_ok_q && !rdy_eff) ? ST_EXT : ST_DONE;
         end
         ST_EXT:  if (rdy_eff) state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         rdy_ok_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) rdy_ok_q <= rdy_ok;
      end
   end

   assign wait_active = (state_q == ST_WAIT) || (state_q == ST_EXT);
   assign cycle_done  = (state_q == ST_DONE);
endmodule

// File: rtl/bus_wait_chk.sv
module bus_wait_chk
   import bus_wait_pkg::*;
#(
   parameter int SET_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             acc_start,
   input logic [1:0]       cfg_mode,
   input logic             later_beat,
   input logic [SET_W-1:0] wset_q,
   input wait_state_e      state_q,
   input logic             rdy_eff,
   input logic             wait_active,
   input logic             cycle_done
);
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
      cycle_done |=> !cycle_done);

   assert_done_excl_R11: assert property (@(posedge clk) disable iff (rst)
      !(cycle_done && wait_active));

   assert_fall_to_done_R11: assert property (@(posedge clk) disable iff (rst)
      $fell(wait_active) |-> cycle_done);

   assert_ext_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_EXT && !rdy_eff) |=> wait_active);

   assert_ext_release_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_EXT && rdy_eff) |=> cycle_done);

   assert_zero_noready_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && acc_start && cfg_mode != 2'd2 && wset_q == '0)
      |=> cycle_done);

   assert_mux_zero_ready_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && acc_start && cfg_mode == 2'd2 && later_beat &&
       !wset_q[2] && !rdy_eff) |=> wait_active);
endmodule

bind bus_wait_gen bus_wait_chk #(.SET_W(SET_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .acc_start   (acc_start),
   .cfg_mode    (cfg_mode),
   .later_beat  (later_beat),
   .wset_q      (wset_q),
   .state_q     (state_q),
   .rdy_eff     (rdy_eff),
   .wait_active (wait_active),
   .cycle_done  (cycle_done)
);

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wset_we = 1'b0;
   logic [3:0] wset_d = '0;
   logic       acc_start = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic       is_write = 1'b0;
   logic       later_beat = 1'b0;
   logic       ext_ready = 1'b1;
   logic       wait_active;
   logic       cycle_done;

   int checks = 0;
   int errors = 0;
   int cur_set = 15;
   int    exp_q[$];
   string tag_q[$];
   int    wcnt = 0;

   always #5 clk = ~clk;

   bus_wait_gen u_bus_wait_gen (
      .clk(clk), .rst(rst), .wset_we(wset_we), .wset_d(wset_d),
      .acc_start(acc_start), .cfg_mode(cfg_mode), .is_write(is_write),
      .later_beat(later_beat), .ext_ready(ext_ready),
      .wait_active(wait_active), .cycle_done(cycle_done)
   );

   // Programmed waits taken from the requirements (R2..R6).
   function automatic int exp_prog(int md, int wr, int lb, int s);
      int sram;
      if (s < 10) sram = s;
      else case (s)
         10: sram = 11; 11: sram = 13; 12: sram = 15;
         13: sram = 17; 14: sram = 21; default: sram = 25;
      endcase
      if (md == 2) begin
         if (lb != 0) return (s >> 2) & 1;
         case (s & 3)
            0: return (wr != 0) ? 0 : 1;
            1: return 1;
            2: return 2;
            default: return 3;
         endcase
      end
      if (md == 1 && lb != 0) return 0;
      return sram;
   endfunction

   // Monitor: counts wait cycles and compares at each done pulse.
   always @(negedge clk) begin
      if (rst) wcnt = 0;
      else if (cycle_done) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected done: actual waits %0d expected no access", wcnt);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (wcnt != e) begin
               errors++;
               $display("FAIL %s: actual waits %0d expected %0d", t, wcnt, e);
            end
         end
         wcnt = 0;
      end else if (wait_active) wcnt++;
   end

   task automatic set_wait(input int v);
      @(negedge clk);
      wset_we = 1'b1;
      wset_d  = 4'(v);
      @(negedge clk);
      wset_we = 1'b0;
      cur_set = v;
   endtask

   // Driver: k = cycles ready is held low after programmed waits.
   task automatic access(input int md, input int wr, input int lb, input int k, input string tag);
      int n, c, guard;
      bit allowed;
      n = exp_prog(md, wr, lb, cur_set);
      allowed = (md == 2) || (cur_set != 0);
      exp_q.push_back(n + (allowed ? k : 0));
      tag_q.push_back(tag);
      @(negedge clk);
      acc_start  = 1'b1;
      cfg_mode   = 2'(md);
      is_write   = wr[0];
      later_beat = lb[0];
      ext_ready  = (n + k == 0);
      @(negedge clk);
      acc_start = 1'b0;
      c = 0;
      guard = 0;
      while (!cycle_done && guard < 200) begin
         if (wait_active) c++;
         ext_ready = (c >= n + k);
         @(negedge clk);
         guard++;
      end
      if (guard >= 200) begin
         checks++;
         errors++;
         $display("FAIL %s: actual no done after 200 cycles expected done", tag);
      end
      ext_ready = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (wait_active !== 1'b0 || cycle_done !== 1'b0) begin
         errors++;
         $display("FAIL R1: actual wait=%b done=%b expected 0 0", wait_active, cycle_done);
      end
      // R1: reset setting is all ones, giving 25 waits
      access(0, 0, 0, 0, "R1");

      // R2 and R3: SRAM-style map across every setting
      for (int s = 0; s < 16; s++) begin
         set_wait(s);
         access(0, 0, 0, 0, (s < 10) ? "R2" : "R3");
      end
      set_wait(12);
      access(3, 1, 0, 0, "R2 code3");

      // R4: burst ROM first and later beats
      set_wait(12);
      access(1, 0, 0, 0, "R4 first");
      access(1, 0, 1, 0, "R4 later");
      access(1, 0, 1, 2, "R7 brom later");

      // R7: extension after programmed waits
      set_wait(5);
      access(0, 0, 0, 3, "R7");
      access(0, 1, 0, 1, "R7");

      // R8: zero setting ignores ready
      set_wait(0);
      access(0, 0, 0, 3, "R8 sram");
      access(1, 0, 1, 3, "R8 brom");

      // R5 and R6: multiplexed map, all settings, both directions and beats
      for (int s = 0; s < 16; s++) begin
         set_wait(s);
         for (int wr = 0; wr < 2; wr++) begin
            access(2, wr, 0, 0, "R5");
            access(2, wr, 1, 0, "R6");
         end
      end

      // R9: ready extends multiplexed accesses with zero programmed waits
      set_wait(0);
      access(2, 1, 0, 2, "R9 first write");
      access(2, 0, 1, 3, "R9 later");
      set_wait(8);
      access(2, 0, 1, 1, "R9 bit3");

      // R10: changes during an access have no effect on it
      set_wait(15);
      fork
         access(0, 0, 0, 0, "R10");
         begin
            repeat (4) @(negedge clk);
            wset_we = 1'b1;
            wset_d  = 4'd0;
            cfg_mode = 2'd2;
            acc_start = 1'b1;
            @(negedge clk);
            wset_we = 1'b0;
            acc_start = 1'b0;
            cur_set = 0;
         end
      join
      access(0, 0, 0, 2, "R10 new setting");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11: actual %0d pending accesses expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule